// File: doc/BRIEF.md
# Single-Cycle Wormhole Mesh Router

This block is a five-port router for a two-dimensional mesh network on chip. Port 0 faces the local node. Ports 1 to 4 face the +X, −X, +Y and −Y neighbours. Packets travel as chains of flits, and each port has a small input FIFO that the upstream sender fills under credit control. In one clock cycle the router routes a flit, arbitrates for the output, spends one downstream credit, updates the ownership state of the output, dequeues the flit and moves it across the crossbar into a registered output stage. A flit written into an empty FIFO therefore appears on its output one clock edge later.

A flit that opens a packet (a head flit or a single-flit packet) is routed dimension-ordered, X first and then Y. The route is computed from the flit's destination coordinates and the router's own coordinates. The new port choice feeds the request logic directly in the same cycle and is also kept for the rest of the packet. The following flits reuse the stored choice. An output stays owned by one input from the head flit to the tail flit. The tail frees the output in the cycle it is granted, so a new packet can follow in the next cycle with no gap.

Top module: `wh_router`

## Requirements
- R1: After reset, every `out_valid` bit and every `crd_ret_up` bit is 0. Every FIFO is empty, every output is free, and every output credit counter holds `CREDITS`. This holds even when the reset lands while flits are buffered.
- R2: A flit that opens a packet goes to +X (port 1) if its destination X is greater than `MY_X` and to −X (port 2) if it is smaller. If the X values are equal, it goes to +Y (port 3) for a larger Y, to −Y (port 4) for a smaller Y, and to local (port 0) if Y is also equal.
- R3: Flit layout, from MSB down: type[1:0], destination X (`COORD_W` bits), destination Y (`COORD_W` bits), payload (`DATA_W` bits). Type 00 is head, 01 body, 10 tail and 11 single-flit packet. A single-flit packet claims its output and frees it in the same cycle, so a packet from another input can use that output in the very next cycle.
- R4: A flit written on clock edge k into an empty FIFO, with its output free and holding credit, appears on `out_valid`/`out_flit` after edge k+1. `crd_ret_up` of its input is 1 during the cycle between those edges, which is the cycle of its dequeue.
- R5: Body and tail flits leave on the output chosen for their packet's head, whatever their destination fields hold.
- R6: While an output is owned by an input's packet, flits from every other input that target that output are held. Their `crd_ret_up` stays 0 and no interleaving occurs.
- R7: When a tail flit is granted, a head flit waiting for the same output is granted in the next cycle, with no idle output cycle between the two packets.
- R8: Each output's credit counter starts at `CREDITS`. It drops by one per flit sent and rises by one per `crd_ret_dn` pulse, and it stays the same when both happen in one cycle. An output with zero credits sends nothing until a credit returns.
- R9: Each output arbitrates round-robin. Its priority pointer moves to the input after the winner only when the winner opens a packet (type 00 or 11).
- R10: An input that receives one flit per cycle sends one flit per cycle while its output is owned and holds credit, because a FIFO is written and read in the same cycle.
- R11: `out_flit` carries the granted flit unchanged, including its type, coordinate and payload fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Per-port flit write strobe from the upstream sender |
| in_flit | input | 5*(2+2*COORD_W+DATA_W) | Incoming flits, port p in slice p |
| crd_ret_up | output | 5 | Per-input credit return to the upstream sender, pulsed on dequeue |
| out_valid | output | 5 | Registered output flit valid, per output port |
| out_flit | output | 5*(2+2*COORD_W+DATA_W) | Registered output flits, port p in slice p |
| crd_ret_dn | input | 5 | Credit return pulses from the downstream buffers |

## Verification
The closest same-cycle interaction is between an output being freed and the same output being claimed again. A tail flit is granted in the very cycle that a waiting head flit from another input becomes eligible. The bench drives two three-flit packets from two inputs to the local port, offset by one cycle, and requires six payloads on six consecutive output cycles. A gap or an interleaved flit counts as a failure. A second overlap, where a credit is spent and returned in the same cycle, is provoked by a downstream model that returns each credit right away during a stream longer than the credit depth. Stalled flits show that this overlap went wrong.

// File: rtl/wh_router.sv
module wh_router #(
  parameter int DATA_W     = 8,
  parameter int COORD_W    = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int CREDITS    = 4,
  parameter int MY_X       = 1,
  parameter int MY_Y       = 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [4:0]                            in_valid,
  input  logic [5*(2+2*COORD_W+DATA_W)-1:0]     in_flit,
  output logic [4:0]                            crd_ret_up,
  output logic [4:0]                            out_valid,
  output logic [5*(2+2*COORD_W+DATA_W)-1:0]     out_flit,
  input  logic [4:0]                            crd_ret_dn
);
  localparam int NP     = 5;
  localparam int FLIT_W = 2 + 2*COORD_W + DATA_W;
  localparam int PW     = $clog2(FIFO_DEPTH);
  localparam int CW     = $clog2(CREDITS+1);

  logic [NP-1:0][FLIT_W-1:0] iflit, oflit_q, head, win;
  logic [FLIT_W-1:0] mem [NP][FIFO_DEPTH];
  logic [PW-1:0] rd_q [NP];
  logic [PW-1:0] wr_q [NP];
  logic [PW:0]   cnt_q [NP];
  logic [2:0] route_q [NP];
  logic [2:0] route_c [NP];
  logic [2:0] route_use [NP];
  logic [2:0] owner_q [NP];
  logic [2:0] ptr_q [NP];
  logic [2:0] win_idx [NP];
  logic [NP-1:0] opens, deq, avail_q, out_valid_q;
  logic [NP-1:0][NP-1:0] req, gnt;
  logic [NP-1:0][CW-1:0] crd_q;

  assign iflit      = in_flit;
  assign out_flit   = oflit_q;
  assign out_valid  = out_valid_q;
  assign crd_ret_up = deq;

  function automatic logic [2:0] xy(input logic [COORD_W-1:0] dx, input logic [COORD_W-1:0] dy);
    if (dx > COORD_W'(MY_X))      return 3'd1;
    else if (dx < COORD_W'(MY_X)) return 3'd2;
    else if (dy > COORD_W'(MY_Y)) return 3'd3;
    else if (dy < COORD_W'(MY_Y)) return 3'd4;
    else                          return 3'd0;
  endfunction

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      head[i]      = mem[i][rd_q[i]];
      opens[i]     = (head[i][FLIT_W-1 -: 2] == 2'b00) || (head[i][FLIT_W-1 -: 2] == 2'b11);
      route_c[i]   = xy(head[i][FLIT_W-3 -: COORD_W], head[i][FLIT_W-3-COORD_W -: COORD_W]);
      route_use[i] = opens[i] ? route_c[i] : route_q[i];
    end
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req[o][i] = (cnt_q[i] != '0) && (route_use[i] == 3'(o)) && (crd_q[o] != '0) &&
                    (avail_q[o] ? opens[i] : (owner_q[o] == 3'(i) && !opens[i]));
  end

  always_comb begin
    int  idx;
    logic hit;
    for (int o = 0; o < NP; o++) begin
      gnt[o]     = '0;
      win[o]     = '0;
      win_idx[o] = '0;
      hit        = 1'b0;
      for (int k = 0; k < NP; k++) begin
        idx = (int'(ptr_q[o]) + k) % NP;
        if (!hit && req[o][idx]) begin
          hit             = 1'b1;
          gnt[o][idx]     = 1'b1;
          win[o]          = head[idx];
          win_idx[o]      = 3'(idx);
        end
      end
    end
    for (int i = 0; i < NP; i++) begin
      deq[i] = 1'b0;
      for (int o = 0; o < NP; o++) deq[i] = deq[i] | gnt[o][i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      if (in_valid[i]) mem[i][wr_q[i]] <= iflit[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        rd_q[i] <= '0; wr_q[i] <= '0; cnt_q[i] <= '0; route_q[i] <= '0;
        owner_q[i] <= '0; ptr_q[i] <= '0;
      end
      avail_q     <= '1;
      out_valid_q <= '0;
      oflit_q     <= '0;
      crd_q       <= {NP{CW'(CREDITS)}};
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (in_valid[i]) wr_q[i] <= wr_q[i] + 1'b1;
        if (deq[i])      rd_q[i] <= rd_q[i] + 1'b1;
        cnt_q[i] <= cnt_q[i] + (PW+1)'(in_valid[i]) - (PW+1)'(deq[i]);
        if (deq[i] && opens[i]) route_q[i] <= route_c[i];
      end
      for (int o = 0; o < NP; o++) begin
        out_valid_q[o] <= |gnt[o];
        oflit_q[o]     <= win[o];
        crd_q[o]       <= crd_q[o] - CW'(|gnt[o]) + CW'(crd_ret_dn[o]);
        if (|gnt[o]) begin
          case (win[o][FLIT_W-1 -: 2])
            2'b00: begin
              avail_q[o] <= 1'b0;
              owner_q[o] <= win_idx[o];
              ptr_q[o]   <= (win_idx[o] == 3'(NP-1)) ? 3'd0 : win_idx[o] + 3'd1;
            end
            2'b11:   ptr_q[o]   <= (win_idx[o] == 3'(NP-1)) ? 3'd0 : win_idx[o] + 3'd1;
            2'b10:   avail_q[o] <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module wh_router_chk #(
  parameter int NP      = 5,
  parameter int CW      = 3,
  parameter int CREDITS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NP-1:0]          out_valid,
  input logic [NP-1:0]          crd_ret_up,
  input logic [NP-1:0]          crd_ret_dn,
  input logic [NP-1:0][CW-1:0]  crd,
  input logic [NP-1:0][NP-1:0]  gnt
);
  p_upstream_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(out_valid) == $past($countones(crd_ret_up)));

  for (genvar o = 0; o < NP; o++) begin : g_out
    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[o]));
    p_stall_no_credit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (crd[o] == '0) |=> !out_valid[o]);
    p_credit_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> int'(crd[o]) == int'($past(crd[o])) - int'(out_valid[o]) + int'($past(crd_ret_dn[o])));
    p_credit_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(crd[o]) <= CREDITS);
  end
endmodule

bind wh_router wh_router_chk #(.NP(NP), .CW(CW), .CREDITS(CREDITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .crd_ret_up(crd_ret_up),
  .crd_ret_dn(crd_ret_dn), .crd(crd_q), .gnt(gnt)
);

// File: tb/tb_wh_router.sv
`timescale 1ns/1ps
module tb_wh_router;
  localparam int NP = 5;
  localparam int FW = 14;
  localparam logic [1:0] TH = 2'b00, TB = 2'b01, TT = 2'b10, TS = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] in_valid = '0, crd_ret_up, out_valid, crd_ret_dn = '0;
  logic [NP-1:0] auto_mask = '1, man_ret = '0;
  logic [NP-1:0][FW-1:0] iflit = '0, oflit;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  wh_router dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(iflit),
    .crd_ret_up(crd_ret_up), .out_valid(out_valid), .out_flit(oflit),
    .crd_ret_dn(crd_ret_dn)
  );

  always @(negedge clk) crd_ret_dn <= (out_valid & auto_mask) | man_ret;

  // {in port, expected out port, flit}; router sits at (1,1)
  localparam logic [19:0] VEC [8] = '{
    {3'd1, 3'd0, TS, 2'd1, 2'd1, 8'h01},
    {3'd0, 3'd1, TS, 2'd2, 2'd1, 8'h02},
    {3'd2, 3'd1, TS, 2'd3, 2'd0, 8'h03},
    {3'd3, 3'd2, TS, 2'd0, 2'd2, 8'h04},
    {3'd4, 3'd3, TS, 2'd1, 2'd3, 8'h05},
    {3'd0, 3'd4, TS, 2'd1, 2'd0, 8'h06},
    {3'd1, 3'd2, TS, 2'd0, 2'd0, 8'h07},
    {3'd2, 3'd3, TS, 2'd1, 2'd2, 8'h08}
  };

  function automatic logic [FW-1:0] mk(logic [1:0] t, logic [1:0] x, logic [1:0] y, logic [7:0] p);
    return {t, x, y, p};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    in_valid = '0;
    iflit = '0;
  endtask

  task automatic put(input int p, input logic [FW-1:0] f);
    in_valid[p] = 1'b1;
    iflit[p] = f;
  endtask

  task automatic want(input int p, input logic [7:0] pay, input string r);
    chk(out_valid[p] && oflit[p][7:0] == pay, r, {out_valid[p], oflit[p][7:0]}, {1'b1, pay});
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(out_valid == '0 && crd_ret_up == '0, "R1 reset outputs", {out_valid, crd_ret_up}, 0);

    // R2 R4 R11: vector walk
    for (int v = 0; v < 8; v++) begin
      int ip, op;
      ip = int'(VEC[v][19:17]);
      op = int'(VEC[v][16:14]);
      clr(); put(ip, VEC[v][13:0]);
      step();
      clr();
      chk(crd_ret_up == NP'(1 << ip), "R4 dequeue credit", crd_ret_up, 1 << ip);
      step();
      chk(out_valid == NP'(1 << op), "R2 route", out_valid, 1 << op);
      chk(oflit[op] == VEC[v][13:0], "R11 flit intact", oflit[op], VEC[v][13:0]);
      step();
    end

    // R5 R6 R7 R10 R8: two packets to local, second one cycle behind
    clr(); put(1, mk(TH, 2'd1, 2'd1, 8'd1));
    step();
    clr(); put(1, mk(TB, 2'd2, 2'd1, 8'd2)); put(2, mk(TH, 2'd1, 2'd1, 8'd10));
    step();
    want(0, 8'd1, "R4 head passes");
    chk(crd_ret_up[2] == 1'b0, "R6 other input masked", crd_ret_up[2], 0);
    clr(); put(1, mk(TT, 2'd3, 2'd3, 8'd3)); put(2, mk(TB, 2'd0, 2'd0, 8'd11));
    step();
    want(0, 8'd2, "R5 body follows head");
    chk(out_valid[1] == 1'b0, "R5 body dst ignored", out_valid[1], 0);
    clr(); put(2, mk(TT, 2'd0, 2'd0, 8'd12));
    step();
    want(0, 8'd3, "R10 tail back to back");
    clr();
    step();
    want(0, 8'd10, "R7 no bubble after tail");
    step();
    want(0, 8'd11, "R6 second packet body");
    step();
    want(0, 8'd12, "R8 credits recycled");
    step();

    // R9 R3: contending single-flit packets from inputs 3 and 4
    clr(); put(3, mk(TS, 2'd1, 2'd1, 8'd30)); put(4, mk(TS, 2'd1, 2'd1, 8'd40));
    step();
    clr(); put(3, mk(TS, 2'd1, 2'd1, 8'd31)); put(4, mk(TS, 2'd1, 2'd1, 8'd41));
    step();
    clr();
    want(0, 8'd30, "R9 pointer start");
    step();
    want(0, 8'd40, "R3 single frees output");
    step();
    want(0, 8'd31, "R9 pointer wraps");
    step();
    want(0, 8'd41, "R9 alternation");
    step();

    // R8: credit exhaustion on +X
    auto_mask[1] = 1'b0;
    for (int k = 0; k < 5; k++) begin
      clr(); put(0, mk(TS, 2'd2, 2'd1, 8'(50 + k)));
      step();
      if (k >= 1) want(1, 8'(50 + k - 1), "R8 credit use");
    end
    clr();
    chk(crd_ret_up[0] == 1'b0, "R8 held at zero credit", crd_ret_up[0], 0);
    step();
    chk(out_valid[1] == 1'b0, "R8 stall", out_valid[1], 0);
    step();
    chk(out_valid[1] == 1'b0, "R8 stall persists", out_valid[1], 0);
    man_ret[1] = 1'b1;
    step();
    man_ret[1] = 1'b0;
    chk(out_valid[1] == 1'b0 && crd_ret_up[0] == 1'b1, "R8 credit return", {out_valid[1], crd_ret_up[0]}, 1);
    step();
    want(1, 8'd54, "R8 resumes");
    step();

    // R1: reset with a buffered flit, then credits full again
    put(0, mk(TH, 2'd2, 2'd1, 8'd99));
    step();
    clr();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    chk(out_valid == '0 && crd_ret_up == '0, "R1 reset flushes", {out_valid, crd_ret_up}, 0);
    put(0, mk(TS, 2'd2, 2'd1, 8'd77));
    step();
    clr();
    step();
    want(1, 8'd77, "R1 credits refilled");
    step();

    finish_run();
  end
endmodule